// File: doc/BRIEF.md
# Multiplexed LCD Common and Segment Waveform Sequencer

This block turns a small byte-organised display image into drive-level selections for the common (backplane) lines and the segment lines of a directly driven liquid crystal panel. A phase sequencer steps through the common lines, and each common phase lasts two LCD clock enables, one of each polarity. For every line a 3-bit code is produced that picks one of five analog levels, from V1 (highest) to V5 (lowest). An external resistor ladder and analog switch use those codes to build an AC waveform with no DC component.

Four drive schemes are offered: static (one common), two-way multiplex at 1/2 bias, and three-way and four-way multiplex at 1/3 bias. The display image is 15 bytes presented in parallel. Each byte feeds a pair of segment lines. The low nibble holds the states of the even line of the pair, the high nibble those of the odd line, one bit per common. A control byte switches the drive on and off, selects the scheme and blanks all segments without touching the image, which is what a flashing display needs. The current common index and polarity are brought out as a frame-phase indicator.

Top module: `lcdWaveSeq`

## Requirements
- R1: ctrlReg[4:3] selects the number of active commons: 00 gives 1 (static), 01 gives 2 (1/2 bias), 10 gives 3 and 11 gives 4 (both 1/3 bias). The mode takes effect on the clock after it is presented. Commons at or above that count are held at V5 while the drive is on.
- R2: Every clock with lcdTick high toggles phasePol. Each time phasePol returns from 1 to 0, phaseCom advances, wrapping after the last active common. A frame therefore lasts 2, 4, 6 or 8 ticks.
- R3: Byte k of dispBytes (bits 8k+7..8k) serves segment lines 2k and 2k+1. In common phase n, line 2k is selected when bit 8k+n is 1 and line 2k+1 when bit 8k+4+n is 1. Bits for commons outside the mode have no effect.
- R4: Level codes are 0..4 for V1..V5. The active common is V1 at polarity 0 and V5 at polarity 1. A selected segment is V5 at polarity 0 and V1 at polarity 1. In static and 1/2-bias modes a non-selected segment follows the active common. In 1/3-bias modes a non-selected segment is V2 at polarity 0 and V4 at polarity 1. Idle commons are V3 in 1/2 bias, and V4 at polarity 0 and V2 at polarity 1 in 1/3 bias.
- R5: When ctrlReg[0] is 0, every common and segment line carries code 4 (V5) at once. The phase is held at common 0, polarity 0.
- R6: When ctrlReg[2] is 0, every segment shows the non-selected level of the current mode and phase, while the commons and the phase keep running.
- R7: A change of ctrlReg[4:3] restarts the phase at common 0, polarity 0 on the next clock.
- R8: Over any whole frame, the sum of COM minus SEG per pixel is zero in every mode. The RMS of each selected pixel exceeds that of every non-selected pixel.
- R9: After reset the phase is common 0, polarity 0 and the stored mode is static.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| lcdTick | input | 1 | LCD clock enable, one half-phase per pulse |
| ctrlReg | input | 8 | Control byte: bit 0 drive on, bit 2 segments shown, bits 4:3 mode |
| dispBytes | input | 120 | Display image, byte k at bits 8k+7..8k |
| comLvl | output | 12 | Level code per common, common j at bits 3j+2..3j |
| segLvl | output | 90 | Level code per segment line, line s at bits 3s+2..3s |
| phaseCom | output | 2 | Index of the active common |
| phasePol | output | 1 | Current half-phase polarity |

## Verification
Several properties hold on every clock and are checked there. The polarity flips on each tick and the common index only moves on the falling edge of polarity. The index never leaves the active range and any mode change restarts it. The active common always carries the full-swing level, a blanked segment never shows the selected level, and the off state drives V5 everywhere. Only the bench scenarios show the per-bit mapping from display bytes to segment lines and the exact idle-common and non-selected levels against an independent model. They also show the frame-level electrical result: zero net DC on every pixel and selected pixels with a larger RMS than non-selected ones in all four schemes.

// File: rtl/lcdSeqPkg.sv
package lcdSeqPkg;
  localparam int LVL_W   = 3;
  localparam int NUM_COM = 4;

  typedef enum logic [1:0] {
    MODE_STATIC = 2'd0,
    MODE_MUX2   = 2'd1,
    MODE_MUX3   = 2'd2,
    MODE_MUX4   = 2'd3
  } lcdMode_e;

  localparam logic [LVL_W-1:0] LVL_V1 = 3'd0;
  localparam logic [LVL_W-1:0] LVL_V2 = 3'd1;
  localparam logic [LVL_W-1:0] LVL_V3 = 3'd2;
  localparam logic [LVL_W-1:0] LVL_V4 = 3'd3;
  localparam logic [LVL_W-1:0] LVL_V5 = 3'd4;

  // strobes from the phase control to the level datapath
  typedef struct packed {
    logic     drive;
    logic     blank;
    lcdMode_e mode;
    logic [1:0] comIdx;
    logic     pol;
  } phaseCtl_t;

  // highest active common index for a mode
  function automatic logic [1:0] lastCom(input lcdMode_e m);
    return 2'(m);
  endfunction
endpackage

// File: rtl/lcdPhaseCtl.sv
module lcdPhaseCtl
  import lcdSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lcdTick,
  input  logic [7:0] ctrlReg,
  output phaseCtl_t  ctl
);
  lcdMode_e   modeQ;
  lcdMode_e   modeIn;
  logic [1:0] comIdx;
  logic       pol;
  logic       restart;

  assign modeIn  = lcdMode_e'(ctrlReg[4:3]);
  assign restart = !ctrlReg[0] || (modeIn != modeQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= MODE_STATIC;
      comIdx <= 2'd0;
      pol    <= 1'b0;
    end else begin
      modeQ <= modeIn;
      if (restart) begin
        comIdx <= 2'd0;
        pol    <= 1'b0;
      end else if (lcdTick) begin
        pol <= ~pol;
        if (pol) begin
          comIdx <= (comIdx == lastCom(modeQ)) ? 2'd0 : comIdx + 2'd1;
        end
      end
    end
  end

  always_comb begin
    ctl.drive  = ctrlReg[0];
    ctl.blank  = !ctrlReg[2];
    ctl.mode   = modeQ;
    ctl.comIdx = comIdx;
    ctl.pol    = pol;
  end

  // R2: each tick flips the polarity
  a_r2_pol_flip: assert property (@(posedge clk) disable iff (!rstN)
    (lcdTick && !restart) |=> (pol != $past(pol)));

  // R2: the common index only moves when polarity falls
  a_r2_com_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!restart && !(lcdTick && pol)) |=> (comIdx == $past(comIdx)));

  // R7: a mode change or drive off restarts the phase
  a_r7_restart: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (comIdx == 2'd0 && !pol));

  // R1: the index stays inside the active commons
  a_r1_com_range: assert property (@(posedge clk) disable iff (!rstN)
    comIdx <= lastCom(modeQ));
endmodule

// File: rtl/lcdLevelPath.sv
module lcdLevelPath
  import lcdSeqPkg::*;
#(
  parameter int NUM_BYTES = 15
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  phaseCtl_t                       ctl,
  input  logic [NUM_BYTES*8-1:0]          dispBytes,
  output logic [NUM_COM*LVL_W-1:0]        comLvl,
  output logic [2*NUM_BYTES*LVL_W-1:0]    segLvl
);
  localparam int NUM_SEG = 2 * NUM_BYTES;

  logic [LVL_W-1:0] lvlComOn;
  logic [LVL_W-1:0] lvlComIdle;
  logic [LVL_W-1:0] lvlSegOn;
  logic [LVL_W-1:0] lvlSegOff;

  always_comb begin
    lvlComOn = ctl.pol ? LVL_V5 : LVL_V1;
    lvlSegOn = ctl.pol ? LVL_V1 : LVL_V5;
    if (ctl.mode == MODE_MUX2) begin
      lvlComIdle = LVL_V3;
    end else begin
      lvlComIdle = ctl.pol ? LVL_V2 : LVL_V4;
    end
    if (ctl.mode == MODE_STATIC || ctl.mode == MODE_MUX2) begin
      lvlSegOff = lvlComOn;
    end else begin
      lvlSegOff = ctl.pol ? LVL_V4 : LVL_V2;
    end
  end

  for (genvar j = 0; j < NUM_COM; j++) begin : g_com
    always_comb begin
      if (!ctl.drive || (2'(j) > lastCom(ctl.mode))) begin
        comLvl[j*LVL_W +: LVL_W] = LVL_V5;
      end else if (2'(j) == ctl.comIdx) begin
        comLvl[j*LVL_W +: LVL_W] = lvlComOn;
      end else begin
        comLvl[j*LVL_W +: LVL_W] = lvlComIdle;
      end
    end
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    localparam int BIT_BASE = (s / 2) * 8 + (s % 2) * 4;
    logic segOn;
    assign segOn = dispBytes[BIT_BASE + int'(ctl.comIdx)] & !ctl.blank;
    always_comb begin
      if (!ctl.drive) begin
        segLvl[s*LVL_W +: LVL_W] = LVL_V5;
      end else begin
        segLvl[s*LVL_W +: LVL_W] = segOn ? lvlSegOn : lvlSegOff;
      end
    end
  end

  // R4: the active common always carries the full-swing level
  a_r4_active_com: assert property (@(posedge clk) disable iff (!rstN)
    ctl.drive |-> (comLvl[ctl.comIdx*LVL_W +: LVL_W] == (ctl.pol ? LVL_V5 : LVL_V1)));

  // R6: a blanked segment never shows the selected level
  a_r6_blank_nonsel: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.drive && ctl.blank) |-> (segLvl[LVL_W-1:0] != (ctl.pol ? LVL_V1 : LVL_V5)));
endmodule

// File: rtl/lcdWaveSeq.sv
module lcdWaveSeq
  import lcdSeqPkg::*;
#(
  parameter int NUM_BYTES = 15
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          lcdTick,
  input  logic [7:0]                    ctrlReg,
  input  logic [NUM_BYTES*8-1:0]        dispBytes,
  output logic [NUM_COM*LVL_W-1:0]      comLvl,
  output logic [2*NUM_BYTES*LVL_W-1:0]  segLvl,
  output logic [1:0]                    phaseCom,
  output logic                          phasePol
);
  localparam int NUM_SEG = 2 * NUM_BYTES;

  phaseCtl_t ctl;

  lcdPhaseCtl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .lcdTick (lcdTick),
    .ctrlReg (ctrlReg),
    .ctl     (ctl)
  );

  lcdLevelPath #(.NUM_BYTES(NUM_BYTES)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .dispBytes (dispBytes),
    .comLvl    (comLvl),
    .segLvl    (segLvl)
  );

  assign phaseCom = ctl.comIdx;
  assign phasePol = ctl.pol;

  // R5: drive off puts every line at V5
  a_r5_off_low: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlReg[0] |-> (comLvl == {NUM_COM{LVL_V5}} && segLvl == {NUM_SEG{LVL_V5}}));
endmodule

// File: tb/lcdWaveSeq_tb.sv
module lcdWaveSeq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB   = 15;
  localparam int NSEG = 2 * NB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lcdTick = 1'b0;
  logic [7:0] ctrlReg = 8'h00;
  logic [NB*8-1:0] dispBytes;
  logic [11:0] comLvl;
  logic [NSEG*3-1:0] segLvl;
  logic [1:0] phaseCom;
  logic phasePol;

  logic [7:0] mem [NB];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int mCom = 0;
  int mPol = 0;
  int mMode = 0;

  bit acc = 0;
  int dcSum [4][NSEG];
  int sqSum [4][NSEG];

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NB; i++) dispBytes[i*8 +: 8] = mem[i];
  end

  lcdWaveSeq u_dut (
    .clk(clk), .rstN(rstN), .lcdTick(lcdTick), .ctrlReg(ctrlReg),
    .dispBytes(dispBytes), .comLvl(comLvl), .segLvl(segLvl),
    .phaseCom(phaseCom), .phasePol(phasePol)
  );

  // level code to voltage on a six-step scale, -99 for an illegal code
  function automatic int volt(input logic [2:0] c);
    case (c)
      3'd0: return 6;
      3'd1: return 4;
      3'd2: return 3;
      3'd3: return 2;
      3'd4: return 0;
      default: return -99;
    endcase
  endfunction

  function automatic int expCom(input int j);
    if (!ctrlReg[0]) return 0;
    if (j > mMode) return 0;
    if (j == mCom) return mPol ? 0 : 6;
    if (mMode == 1) return 3;
    return mPol ? 4 : 2;
  endfunction

  function automatic int expSeg(input int s);
    int b;
    bit sel;
    if (!ctrlReg[0]) return 0;
    b = (s % 2) * 4 + mCom;
    sel = mem[s / 2][b] && ctrlReg[2];
    if (sel) return mPol ? 6 : 0;
    if (mMode <= 1) return mPol ? 0 : 6;
    return mPol ? 2 : 4;
  endfunction

  task automatic compareAll(input string tag);
    int bad = 0;
    checks++;
    if (phaseCom != 2'(mCom) || phasePol != mPol[0]) begin
      bad = 1;
      $display("FAIL %s R2 phase com=%0d pol=%0d expected com=%0d pol=%0d",
               tag, phaseCom, phasePol, mCom, mPol);
    end
    for (int j = 0; j < 4; j++) begin
      if (volt(comLvl[j*3 +: 3]) != expCom(j)) begin
        bad = 1;
        $display("FAIL %s R4 com%0d volt=%0d expected=%0d", tag, j,
                 volt(comLvl[j*3 +: 3]), expCom(j));
      end
    end
    for (int s = 0; s < NSEG; s++) begin
      if (volt(segLvl[s*3 +: 3]) != expSeg(s)) begin
        bad = 1;
        $display("FAIL %s R3 seg%0d volt=%0d expected=%0d", tag, s,
                 volt(segLvl[s*3 +: 3]), expSeg(s));
      end
    end
    if (bad) errors++;
    if (acc) begin
      for (int c = 0; c < 4; c++) begin
        for (int s = 0; s < NSEG; s++) begin
          int d;
          d = volt(comLvl[c*3 +: 3]) - volt(segLvl[s*3 +: 3]);
          dcSum[c][s] += d;
          sqSum[c][s] += d * d;
        end
      end
    end
  endtask

  task automatic updateModel(input bit tk);
    if (!ctrlReg[0] || int'(ctrlReg[4:3]) != mMode) begin
      mCom = 0;
      mPol = 0;
    end else if (tk) begin
      if (mPol == 1) begin
        mPol = 0;
        mCom = (mCom == mMode) ? 0 : mCom + 1;
      end else begin
        mPol = 1;
      end
    end
    mMode = int'(ctrlReg[4:3]);
  endtask

  task automatic step(input bit tk, input string tag);
    @(negedge clk);
    lcdTick = tk;
    #1;
    compareAll(tag);
    @(posedge clk);
    updateModel(tk);
    #1;
  endtask

  function automatic logic [7:0] modeCtrl(input int m, input bit shown);
    return 8'((m << 3) | (int'(shown) << 2) | 1);
  endfunction

  // R8: one whole frame, zero DC and RMS ordering
  task automatic frameCheck(input int m);
    int minSel = 1 << 30;
    int maxNon = -1;
    int dcBad = 0;
    ctrlReg = modeCtrl(m, 1'b1);
    step(1'b0, "R7 restart");
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < NSEG; s++) begin
        dcSum[c][s] = 0;
        sqSum[c][s] = 0;
      end
    acc = 1;
    for (int k = 0; k < 2 * (m + 1); k++) step(1'b1, "R8 frame");
    acc = 0;
    for (int c = 0; c <= m; c++)
      for (int s = 0; s < NSEG; s++) begin
        if (dcSum[c][s] != 0) dcBad++;
        if (mem[s / 2][(s % 2) * 4 + c]) begin
          if (sqSum[c][s] < minSel) minSel = sqSum[c][s];
        end else begin
          if (sqSum[c][s] > maxNon) maxNon = sqSum[c][s];
        end
      end
    checks++;
    if (dcBad != 0) begin
      errors++;
      $display("FAIL R8 mode %0d DC pixels=%0d expected=0", m, dcBad);
    end
    checks++;
    if (!(minSel > maxNon)) begin
      errors++;
      $display("FAIL R8 mode %0d rms minSel=%0d maxNon=%0d expected minSel>maxNon",
               m, minSel, maxNon);
    end
  endtask

  initial begin
    logic [7:0] lfsr = 8'h5B;
    for (int i = 0; i < NB; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem[i] = lfsr;
    end
    mem[0] = 8'hA5;
    mem[1] = 8'h3C;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    // R9: reset state, R5: drive off
    checks++;
    if (phaseCom != 2'd0 || phasePol != 1'b0) begin
      errors++;
      $display("FAIL R9 reset phase com=%0d pol=%0d expected 0 0", phaseCom, phasePol);
    end
    step(1'b1, "R5 off in reset");
    rstN = 1'b1;
    #1;
    for (int k = 0; k < 4; k++) step(1'b1, "R5 off");

    // R1 R2 R3 R4: each mode, continuous ticks, several frames
    for (int m = 0; m < 4; m++) begin
      ctrlReg = modeCtrl(m, 1'b1);
      for (int k = 0; k < 20; k++) step(1'b1, "R1 mode run");
    end

    // R8 frame checks in each mode
    for (int m = 0; m < 4; m++) frameCheck(m);

    // R2: sparse ticks in 3MUX
    ctrlReg = modeCtrl(2, 1'b1);
    for (int k = 0; k < 30; k++) step(k % 3 == 0, "R2 sparse ticks");

    // R6: blanking in 4MUX and 2MUX, then show again
    ctrlReg = modeCtrl(3, 1'b0);
    for (int k = 0; k < 12; k++) step(1'b1, "R6 blank 4mux");
    ctrlReg = modeCtrl(1, 1'b0);
    for (int k = 0; k < 6; k++) step(1'b1, "R6 blank 2mux");
    ctrlReg = modeCtrl(1, 1'b1);
    for (int k = 0; k < 6; k++) step(1'b1, "R6 unblank");

    // R7: mode change in mid-frame
    ctrlReg = modeCtrl(3, 1'b1);
    for (int k = 0; k < 5; k++) step(1'b1, "R7 pre");
    ctrlReg = modeCtrl(2, 1'b1);
    for (int k = 0; k < 8; k++) step(1'b1, "R7 post");

    // R5: drive off mid-frame, then back on
    ctrlReg = modeCtrl(2, 1'b1) & 8'hFE;
    for (int k = 0; k < 4; k++) step(1'b1, "R5 off mid");
    ctrlReg = modeCtrl(2, 1'b1);
    for (int k = 0; k < 8; k++) step(1'b1, "R5 back on");

    // R3: new image in static mode, high-nibble bits unused by the mode
    for (int i = 0; i < NB; i++) mem[i] = 8'(i * 37 + 11);
    ctrlReg = modeCtrl(0, 1'b1);
    for (int k = 0; k < 6; k++) step(1'b1, "R3 static image");
    for (int i = 0; i < NB; i++) mem[i] = mem[i] ^ 8'hEE;
    for (int k = 0; k < 6; k++) step(1'b1, "R3 unused bits");

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule